// File: doc/BRIEF.md
# Chained Raster Timing Counter Bank

This block is a bank of general-purpose timing counters that together produce the timing of a raster display. It has no dedicated horizontal or vertical counter. Each counter advances on ticks from a source that software selects. A source can be the pixel clock or the period event of another counter. Each counter also has a start offset counted in ticks of its own offset source, a repeat limit, a clear source, and an output window placed in half-tick units. Chaining the counters yields the internal line sync, a delayed external line sync, the frame sync, the active-line and active-pixel windows, and a data-enable strobe built from those two windows.

Software programs the counters through a write port while the run enable is low. Raising the enable starts every counter in the same cycle. A typical chain works as follows. Counter 1 divides the pixel clock by the line total. Counter 2 copies that line period after a pixel delay and provides the external HSYNC. Counter 3 counts lines to form VSYNC. Counter 4 is cleared by VSYNC and marks the visible lines. Counter 5 is restarted by every visible-line event and marks the visible pixels.

Top module: `raster_wavegen`

## Requirements
- R1: A write with `cfg_wr` high stores `cfg_data` at `cfg_addr`. The address is {counter index[5:2], word[1:0]}. Word 0 holds run count in [11:0], run source in [15:12], offset count in [27:16] and offset source in [31:28]. Word 1 holds repeat count in [11:0] and clear source in [15:12]. Word 2 holds the window start in [9:0] and the window end in [25:16]. Index 0, word 0 holds the polarity bits: bit 0 for HSYNC, bit 1 for VSYNC, bit 2 for data enable.
- R2: While `run_en` is low, and after reset, every counter is idle, all windows are low, and each output rests at the level of its polarity bit. After reset that level is 0.
- R3: In the first cycle `run_en` is high, all counters are cleared together. A counter with a zero offset begins its first period immediately. A counter with a nonzero offset N begins its first period on the N-th tick of its offset source.
- R4: A counter's period is run count + 1 ticks of its run source. Source fields select tap value−1: value 1 is the pixel clock (every cycle), value k+1 is the event of counter k, and value 0 means no source. A counter with no run source never leaves phase 0.
- R5: A counter emits a one-cycle event when its period wraps and when its offset expires, but not when it is cleared. A counter that consumes the event sees it one cycle later.
- R6: A repeat count of zero makes a counter free-running. A nonzero repeat count R stops the counter after R periods, and it stays silent until it is cleared again.
- R7: A counter's window is high while the counter is running and start ≤ 2·phase < end. A sync of N ticks is therefore programmed with end = start + 2N. An end at or below the start gives no pulse.
- R8: A tick from the clear source restarts the counter from its offset. Clearing has priority over counting.
- R9: `hsync_o` is the window of counter HS_SEL and `vsync_o` is the window of counter VS_SEL. `de_o` is the AND of the windows of counters LINE_SEL and PIX_SEL. `strobe_o` carries every counter's window.
- R10: Each of the three polarity bits, when set, inverts its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; counters idle while low and start together on its rise |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_data | input | 32 | Configuration write data |
| hsync_o | output | 1 | External line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| strobe_o | output | NUM_CNT | Raw window of each counter, index 1 at bit 0 |

## Verification
Outputs decode the counter state combinationally, so a window value is due right after the clock edge that updates the counter's state. Each event hop between chained counters adds exactly one cycle. As a result, VSYNC line boundaries trail the line-sync wrap by one cycle, visible lines begin one cycle after the line event, and a visible pixel run begins two cycles after a line boundary plus the pixel offset. The bench counts edges from the first edge with the enable high and computes all three outputs for each cycle from the panel geometry using these latencies. It samples on the falling edge, half a period after the edge that updated the state.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

    localparam int SEL_W  = 4;
    localparam int CNT_W  = 12;
    localparam int WIN_W  = 10;
    localparam int TAP_N  = 1 << SEL_W;
    localparam int ADDR_W = SEL_W + 2;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } cnt_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] off_src;
        logic [CNT_W-1:0] off_cnt;
        logic [SEL_W-1:0] run_src;
        logic [CNT_W-1:0] run_cnt;
        logic [SEL_W-1:0] clr_src;
        logic [CNT_W-1:0] rep_cnt;
        logic [WIN_W-1:0] win_end;
        logic [WIN_W-1:0] win_beg;
    } cnt_cfg_t;

    typedef struct packed {
        logic de;
        logic vs;
        logic hs;
    } pol_t;

    // Selector value 0 means no source; value s takes tap s-1.
    function automatic logic pick_tap(input logic [TAP_N-1:0] taps,
                                      input logic [SEL_W-1:0] sel);
        return (sel == '0) ? 1'b0 : taps[sel - 1'b1];
    endfunction

    // Window test in half-tick units.
    function automatic logic in_window(input logic [CNT_W-1:0] ph,
                                       input logic [WIN_W-1:0] wbeg,
                                       input logic [WIN_W-1:0] wend);
        logic [CNT_W:0] half;
        half = {ph, 1'b0};
        return (half >= (CNT_W+1)'(wbeg)) && (half < (CNT_W+1)'(wend));
    endfunction

endpackage

// File: rtl/rwg_cfg_regs.sv
module rwg_cfg_regs
    import rwg_pkg::*;
#(
    parameter int NUM_CNT = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output cnt_cfg_t [NUM_CNT:1]     cfg_o,
    output pol_t                     pol_o
);

    logic [SEL_W-1:0] idx;
    logic [1:0]       word;

    assign idx  = wr_addr[ADDR_W-1:2];
    assign word = wr_addr[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
            pol_o <= '0;
        end else if (wr_en) begin
            if (idx == '0 && word == 2'd0)
                pol_o <= pol_t'(wr_data[2:0]);
            for (int k = 1; k <= NUM_CNT; k++) begin
                if (idx == SEL_W'(k)) begin
                    case (word)
                        2'd0: begin
                            cfg_o[k].run_cnt <= wr_data[11:0];
                            cfg_o[k].run_src <= wr_data[15:12];
                            cfg_o[k].off_cnt <= wr_data[27:16];
                            cfg_o[k].off_src <= wr_data[31:28];
                        end
                        2'd1: begin
                            cfg_o[k].rep_cnt <= wr_data[11:0];
                            cfg_o[k].clr_src <= wr_data[15:12];
                        end
                        2'd2: begin
                            cfg_o[k].win_beg <= wr_data[9:0];
                            cfg_o[k].win_end <= wr_data[25:16];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/rwg_counter.sv
module rwg_counter
    import rwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  cnt_cfg_t          cfg,
    input  logic [TAP_N-1:0]  taps,
    output logic              evt_o,
    output logic              wave_o,
    output logic              clr_o,
    output cnt_state_e        state_o,
    output logic [CNT_W-1:0]  ph_o,
    output logic [CNT_W-1:0]  reps_o
);

    cnt_state_e       state;
    logic [CNT_W-1:0] ph;
    logic [CNT_W-1:0] off_ph;
    logic [CNT_W-1:0] reps;
    logic             evt;
    logic             rtick;
    logic             otick;
    logic             clr;

    assign rtick = pick_tap(taps, cfg.run_src);
    assign otick = pick_tap(taps, cfg.off_src);
    assign clr   = start | pick_tap(taps, cfg.clr_src);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= ST_IDLE;
            ph     <= '0;
            off_ph <= '0;
            reps   <= '0;
            evt    <= 1'b0;
        end else if (clr) begin
            evt    <= 1'b0;
            ph     <= '0;
            off_ph <= '0;
            reps   <= CNT_W'(1);
            state  <= (cfg.off_cnt == '0) ? ST_RUN : ST_DELAY;
        end else begin
            evt <= 1'b0;
            case (state)
                ST_DELAY: begin
                    if (otick) begin
                        if (off_ph == cfg.off_cnt - CNT_W'(1)) begin
                            state <= ST_RUN;
                            ph    <= '0;
                            evt   <= 1'b1;
                        end else begin
                            off_ph <= off_ph + CNT_W'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (rtick) begin
                        if (ph == cfg.run_cnt) begin
                            if (cfg.rep_cnt != '0 && reps == cfg.rep_cnt) begin
                                state <= ST_DONE;
                            end else begin
                                ph   <= '0;
                                reps <= reps + CNT_W'(1);
                                evt  <= 1'b1;
                            end
                        end else begin
                            ph <= ph + CNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign evt_o   = evt;
    assign clr_o   = clr;
    assign state_o = state;
    assign ph_o    = ph;
    assign reps_o  = reps;
    assign wave_o  = (state == ST_RUN) && in_window(ph, cfg.win_beg, cfg.win_end);

endmodule

// File: rtl/raster_wavegen.sv
module raster_wavegen
    import rwg_pkg::*;
#(
    parameter int NUM_CNT  = 5,
    parameter int HS_SEL   = 2,
    parameter int VS_SEL   = 3,
    parameter int LINE_SEL = 4,
    parameter int PIX_SEL  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_data,
    output logic                hsync_o,
    output logic                vsync_o,
    output logic                de_o,
    output logic [NUM_CNT-1:0]  strobe_o
);

    cnt_cfg_t   [NUM_CNT:1]            cnt_cfg;
    pol_t                              pol;
    logic                              en_q;
    logic                              start;
    logic       [TAP_N-1:0]            taps;
    logic       [NUM_CNT:1]            cnt_evt;
    logic       [NUM_CNT:1]            cnt_wave;
    logic       [NUM_CNT:1]            cnt_clr;
    cnt_state_e [NUM_CNT:1]            cnt_state;
    logic       [NUM_CNT:1][CNT_W-1:0] cnt_ph;
    logic       [NUM_CNT:1][CNT_W-1:0] cnt_reps;

    rwg_cfg_regs #(.NUM_CNT(NUM_CNT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .cfg_o   (cnt_cfg),
        .pol_o   (pol)
    );

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= run_en;
    end

    assign start = run_en & ~en_q;

    always_comb begin
        taps            = '0;
        taps[0]         = 1'b1;
        taps[NUM_CNT:1] = cnt_evt;
    end

    for (genvar k = 1; k <= NUM_CNT; k++) begin : g_cnt
        rwg_counter u_cnt (
            .clk     (clk),
            .rst     (rst),
            .en      (run_en),
            .start   (start),
            .cfg     (cnt_cfg[k]),
            .taps    (taps),
            .evt_o   (cnt_evt[k]),
            .wave_o  (cnt_wave[k]),
            .clr_o   (cnt_clr[k]),
            .state_o (cnt_state[k]),
            .ph_o    (cnt_ph[k]),
            .reps_o  (cnt_reps[k])
        );
    end

    assign hsync_o  = cnt_wave[HS_SEL] ^ pol.hs;
    assign vsync_o  = cnt_wave[VS_SEL] ^ pol.vs;
    assign de_o     = (cnt_wave[LINE_SEL] & cnt_wave[PIX_SEL]) ^ pol.de;
    assign strobe_o = cnt_wave;

endmodule

// File: rtl/raster_wavegen_chk.sv
module raster_wavegen_chk
    import rwg_pkg::*;
#(
    parameter int NUM_CNT = 5
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              run_en,
    input logic                              start,
    input logic       [NUM_CNT:1]            clr,
    input logic       [NUM_CNT:1]            evt,
    input cnt_state_e [NUM_CNT:1]            state,
    input logic       [NUM_CNT:1][CNT_W-1:0] ph,
    input logic       [NUM_CNT:1][CNT_W-1:0] reps,
    input cnt_cfg_t   [NUM_CNT:1]            cfg
);

    for (genvar k = 1; k <= NUM_CNT; k++) begin : g_k
        // R2: enable low leaves the counter idle and silent
        p_idle_after_off_r2: assert property (@(posedge clk) disable iff (rst)
            !run_en |=> (state[k] == ST_IDLE) && !evt[k])
            else $error("p_idle_after_off_r2 counter %0d", k);

        // R3: the start cycle arms every counter
        p_start_arms_r3: assert property (@(posedge clk) disable iff (rst)
            start |=> (state[k] != ST_IDLE))
            else $error("p_start_arms_r3 counter %0d", k);

        // R4: phase never passes the run count
        p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
            (state[k] == ST_RUN) |-> (ph[k] <= cfg[k].run_cnt))
            else $error("p_phase_bound_r4 counter %0d", k);

        // R5: a stopped counter emits nothing until cleared
        p_done_silent_r5: assert property (@(posedge clk) disable iff (rst)
            (run_en && !clr[k] && state[k] == ST_DONE) |=> (state[k] == ST_DONE) && !evt[k])
            else $error("p_done_silent_r5 counter %0d", k);

        // R6: period count stays within the repeat limit
        p_reps_bound_r6: assert property (@(posedge clk) disable iff (rst)
            (state[k] == ST_RUN && cfg[k].rep_cnt != '0) |-> (reps[k] != '0) && (reps[k] <= cfg[k].rep_cnt))
            else $error("p_reps_bound_r6 counter %0d", k);

        // R8: a clear restarts from the offset
        p_clear_restarts_r8: assert property (@(posedge clk) disable iff (rst)
            (run_en && clr[k]) |=> ((cfg[k].off_cnt == '0) ? (state[k] == ST_RUN && ph[k] == '0)
                                                          : (state[k] == ST_DELAY)))
            else $error("p_clear_restarts_r8 counter %0d", k);
    end

endmodule

bind raster_wavegen raster_wavegen_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .start  (start),
    .clr    (cnt_clr),
    .evt    (cnt_evt),
    .state  (cnt_state),
    .ph     (cnt_ph),
    .reps   (cnt_reps),
    .cfg    (cnt_cfg)
);

// File: tb/raster_wavegen_tb_top.sv
`timescale 1ns/1ps
module raster_wavegen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        hsync_o, vsync_o, de_o;
    logic [4:0]  strobe_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // geometry
    int g_w, g_ht, g_hsw, g_hst, g_he, g_vsw, g_vst, g_ve, g_dly, g_up;
    int g_htot, g_vtot;
    bit g_hs_zero, g_vs_stuck;
    bit [2:0] g_pol;

    always #4 clk = ~clk;

    raster_wavegen dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .strobe_o(strobe_o)
    );

    task automatic chk(input bit act, input bit exp, input string tag, input int n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d got %0b expected %0b", tag, n, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int word, input logic [31:0] d);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_addr = 6'((idx << 2) | word);
        cfg_data = d;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic prog_cnt(input int k, input int run, input int rsrc, input int off,
                            input int osrc, input int rep, input int csrc,
                            input int wbeg, input int wend);
        wr(k, 0, {4'(osrc), 12'(off), 4'(rsrc), 12'(run)});
        wr(k, 1, {16'd0, 4'(csrc), 12'(rep)});
        wr(k, 2, {6'd0, 10'(wend), 6'd0, 10'(wbeg)});
    endtask

    task automatic program_geom();
        if (g_ve < 2) g_ve = 2;
        g_htot = g_w + g_hsw + g_hst + g_he;
        g_vtot = g_ht + g_vsw + g_vst + g_ve;
        wr(0, 0, {29'd0, g_pol});
        prog_cnt(1, g_htot-1, 1, 0, 0, 0, 0, 0, 0);
        prog_cnt(2, g_htot-1, 1, g_dly, 1, 0, 0, 2*g_up, g_hs_zero ? 0 : 2*(g_up+g_hsw));
        prog_cnt(3, g_vtot-1, g_vs_stuck ? 0 : 2, 0, 0, 0, 0, 0, 2*g_vsw);
        prog_cnt(4, 0, 2, g_vsw+g_vst, 2, g_ht, 4, 0, 2);
        prog_cnt(5, 0, 1, g_hsw+g_hst, 1, g_w, 5, 0, 2);
    endtask

    function automatic bit e_hs(int n);
        int x;
        if (g_hs_zero || n < g_dly) return 1'b0;
        x = (n - g_dly) % g_htot;
        return (x >= g_up) && (x < g_up + g_hsw);
    endfunction

    function automatic bit e_vs(int n);
        int line;
        if (g_vs_stuck) return 1'b1;
        line = (n == 0) ? 0 : (n - 1) / g_htot;
        return (line % g_vtot) < g_vsw;
    endfunction

    function automatic bit e_de(int n);
        int q, l, x, lv, o;
        q = n - 2 - (g_hsw + g_hst);
        if (q < 0) return 1'b0;
        l = q / g_htot;
        x = q % g_htot;
        if (x >= g_w) return 1'b0;
        if (g_vs_stuck && l >= g_vtot) return 1'b0;
        lv = l % g_vtot;
        o  = g_vsw + g_vst;
        return (lv >= o) && (lv < o + g_ht);
    endfunction

    task automatic run_frames(input int frames, input string hs_tag,
                              input string vs_tag, input string de_tag);
        @(negedge clk);
        run_en = 1'b1;
        for (int n = 0; n < frames * g_htot * g_vtot; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk(hsync_o, e_hs(n) ^ g_pol[0], hs_tag, n);
            chk(vsync_o, e_vs(n) ^ g_pol[1], vs_tag, n);
            chk(de_o,    e_de(n) ^ g_pol[2], de_tag, n);
        end
        run_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(hsync_o, g_pol[0], "R2 idle hsync after enable drop", -1);
        chk(vsync_o, g_pol[1], "R2 idle vsync after enable drop", -1);
        chk(de_o,    g_pol[2], "R2 idle de after enable drop", -1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        chk(hsync_o, 1'b0, "R2 reset hsync", 0);
        chk(vsync_o, 1'b0, "R2 reset vsync", 0);
        chk(de_o,    1'b0, "R2 reset de", 0);
        chk(|strobe_o, 1'b0, "R2 reset windows", 0);

        // geometry A: delayed sync, positive polarity
        g_w = 8; g_ht = 4; g_hsw = 2; g_hst = 3; g_he = 2;
        g_vsw = 1; g_vst = 2; g_ve = 2; g_dly = 1; g_up = 0;
        g_pol = 3'b000; g_hs_zero = 0; g_vs_stuck = 0;
        program_geom();
        run_frames(3, "R3 R7 hsync geomA", "R4 R5 vsync geomA", "R6 R8 R9 de geomA");

        // geometry B: inverted polarities, shifted window start, zero delay
        g_w = 12; g_ht = 3; g_hsw = 3; g_hst = 2; g_he = 1;
        g_vsw = 2; g_vst = 1; g_ve = 1; g_dly = 0; g_up = 1;
        g_pol = 3'b111;
        program_geom();
        @(negedge clk);
        chk(hsync_o, 1'b1, "R1 R10 idle hsync inverted", -1);
        chk(vsync_o, 1'b1, "R1 R10 idle vsync inverted", -1);
        chk(de_o,    1'b1, "R1 R10 idle de inverted", -1);
        run_frames(3, "R3 R7 R10 hsync geomB", "R4 R5 R10 vsync geomB", "R6 R8 R9 R10 de geomB");

        // geometry C: empty hsync window, frame counter with no run source
        g_pol = 3'b000; g_hs_zero = 1; g_vs_stuck = 1;
        program_geom();
        run_frames(2, "R7 zero-width hsync", "R4 no-source vsync", "R6 R8 single-frame de");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule